// File: doc/BRIEF.md
# Bridge Fault Supervisor

This block decides, cycle by cycle, whether one full power bridge may conduct. It takes the external enable request, a one-bit overcurrent flag, a digital die-temperature code and a digital supply-voltage code. From these it drives an effective bridge-enable and a pull-down request. The pull-down request models an open-drain device that drags the shared enable line low. The enable line behaves as a wired-AND: a low level from any source turns every switch of the bridge off.

When the overcurrent flag is seen, a trip delay starts. Its length in cycles is set by `trip_delay`. When the delay ends, the pull-down is asserted and held for `dis_time` cycles, after which the bridge is released. This release is timed; nothing latches. If the flag is still high when the hold expires, the hold starts again instead of releasing the bridge.

Thermal shutdown and supply undervoltage lockout each use two thresholds, so each has hysteresis. The temperature trip point and its hysteresis band, and the supply release and lockout levels, are parameters. Their default codes stand for roughly 165 °C with a 15 °C band, and for 6.3 V and 5.5 V in tenths of a volt. The asynchronous active-low reset is released synchronously. Reset leaves the bridge undervoltage-locked.

Top module: `bridge_guard`

## Requirements
- R1: During reset and after it, `bridge_en` and `en_pull` are 0. The block stays undervoltage-locked until `vsup_code` exceeds `V_ON`, even if the supply code is already above `V_OFF`.
- R2: `bridge_en` is 1 only when all four of these hold: `en_req` is high, the pull-down is inactive, there is no thermal fault and there is no undervoltage. A low `en_req` drops `bridge_en` combinationally, in the same cycle.
- R3: When `oc_flag` is sampled high while the supervisor is idle, `en_pull` rises after exactly `trip_delay` clock edges have passed without a pull-down. When `trip_delay` is 0, `en_pull` is already high after the first edge.
- R4: `en_pull` stays high for exactly `dis_time` cycles and is then released. A `dis_time` of 0 acts as 1.
- R5: A high `oc_flag` during the trip delay, or during the hold before its last cycle, has no effect. If `oc_flag` is high at the edge where the hold expires, a new hold of `dis_time` cycles starts.
- R6: The thermal fault sets at the edge where `temp_code >= T_TRIP`. It clears only at an edge where `temp_code < T_TRIP - T_HYS`, so `bridge_en` follows one cycle after the code.
- R7: Undervoltage sets at an edge where `vsup_code < V_OFF` and clears at an edge where `vsup_code > V_ON`. Between the two levels the previous state is kept.
- R8: While `en_pull` is high, `bridge_en` is 0. The overcurrent sequence runs whatever the level of `en_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_req | input | 1 | External enable request driven onto the shared line |
| oc_flag | input | 1 | High-side overcurrent comparator result |
| temp_code | input | TEMP_W | Die temperature code |
| vsup_code | input | VS_W | Supply voltage code |
| trip_delay | input | DLY_W | Cycles from overcurrent detection to the pull-down |
| dis_time | input | TIME_W | Cycles the pull-down is held |
| bridge_en | output | 1 | Effective bridge enable |
| en_pull | output | 1 | Pull-down request on the shared enable line |

## Verification
The properties assume that `oc_flag`, `temp_code` and `vsup_code` are already synchronous to `clk`, and that `trip_delay` and `dis_time` change only while no overcurrent sequence is in progress. The stimulus obeys both assumptions. Every input is driven on the falling edge, and the timing settings are changed only after a pull-down has been observed to end. With a small counter configuration, the bench can sweep every pair of delay and hold values. It also ramps the temperature and supply codes across both thresholds in each direction. The expected enable for each code comes from a two-level model inside the bench.

// File: rtl/bg_pkg.sv
package bg_pkg;

  typedef enum logic [1:0] {
    OC_IDLE = 2'd0,
    OC_WAIT = 2'd1,
    OC_HOLD = 2'd2
  } oc_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bg_rst_sync.sv
module bg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 2'b00;
    end else begin
      sh_q <= {sh_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sh_q[1];

endmodule

// File: rtl/bg_hyst.sv
// Two-level comparator with memory. SET_HIGH picks whether the flag trips
// on a high code (temperature) or a low code (supply).
module bg_hyst #(
  parameter int W        = 8,
  parameter int SET_LVL  = 0,
  parameter int CLR_LVL  = 0,
  parameter bit SET_HIGH = 1'b1,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         flag
);

  localparam logic [W-1:0] SET_C = W'(SET_LVL);
  localparam logic [W-1:0] CLR_C = W'(CLR_LVL);

  logic set_hit;
  logic clr_hit;
  logic flip;
  logic flag_q;

  generate
    if (SET_HIGH) begin : g_trip_high
      always_comb begin
        set_hit = (level >= SET_C);
        clr_hit = (level <  CLR_C);
      end
    end else begin : g_trip_low
      always_comb begin
        set_hit = (level <  SET_C);
        clr_hit = (level >  CLR_C);
      end
    end
  endgenerate

  always_comb begin
    flip = flag_q ? clr_hit : set_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
    end else if (flip) begin
      flag_q <= ~flag_q;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/bg_oc_seq.sv
// Overcurrent sequencer: idle -> trip delay -> timed hold -> idle.
// One counter serves both the delay and the hold phases.
module bg_oc_seq
  import bg_pkg::*;
#(
  parameter int DLY_W  = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_flag,
  input  logic [DLY_W-1:0]  trip_delay,
  input  logic [TIME_W-1:0] dis_time,
  output logic              pull_req
);

  localparam int CNT_W = max2(DLY_W, TIME_W);

  oc_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_len;
  logic [CNT_W-1:0] dly_len;
  logic             cnt_last;
  logic             adv;

  always_comb begin
    hold_len = (dis_time == '0) ? CNT_W'(1) : CNT_W'(dis_time);
    dly_len  = CNT_W'(trip_delay);
    cnt_last = (cnt_q <= CNT_W'(1));
    adv      = (st_q != OC_IDLE) || oc_flag;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      OC_IDLE: begin
        if (oc_flag) begin
          if (trip_delay == '0) begin
            st_d  = OC_HOLD;
            cnt_d = hold_len;
          end else begin
            st_d  = OC_WAIT;
            cnt_d = dly_len;
          end
        end
      end
      OC_WAIT: begin
        if (cnt_last) begin
          st_d  = OC_HOLD;
          cnt_d = hold_len;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      OC_HOLD: begin
        if (cnt_last) begin
          if (oc_flag) begin
            cnt_d = hold_len;
          end else begin
            st_d = OC_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        st_d = OC_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OC_IDLE;
      cnt_q <= '0;
    end else if (adv) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign pull_req = (st_q == OC_HOLD);

endmodule

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int TEMP_W = 8,
  parameter int VS_W   = 8,
  parameter int DLY_W  = 8,
  parameter int TIME_W = 16,
  parameter int T_TRIP = 165,
  parameter int T_HYS  = 15,
  parameter int V_ON   = 63,
  parameter int V_OFF  = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req,
  input  logic              oc_flag,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [VS_W-1:0]   vsup_code,
  input  logic [DLY_W-1:0]  trip_delay,
  input  logic [TIME_W-1:0] dis_time,
  output logic              bridge_en,
  output logic              en_pull
);

  localparam int T_CLR = T_TRIP - T_HYS;

  logic rst_i_n;
  logic pull;
  logic hot;
  logic uv;

  bg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  bg_oc_seq #(
    .DLY_W  (DLY_W),
    .TIME_W (TIME_W)
  ) u_oc (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .oc_flag    (oc_flag),
    .trip_delay (trip_delay),
    .dis_time   (dis_time),
    .pull_req   (pull)
  );

  bg_hyst #(
    .W        (TEMP_W),
    .SET_LVL  (T_TRIP),
    .CLR_LVL  (T_CLR),
    .SET_HIGH (1'b1),
    .RST_VAL  (1'b0)
  ) u_therm (
    .clk   (clk),
    .rst_n (rst_i_n),
    .level (temp_code),
    .flag  (hot)
  );

  bg_hyst #(
    .W        (VS_W),
    .SET_LVL  (V_OFF),
    .CLR_LVL  (V_ON),
    .SET_HIGH (1'b0),
    .RST_VAL  (1'b1)
  ) u_uvlo (
    .clk   (clk),
    .rst_n (rst_i_n),
    .level (vsup_code),
    .flag  (uv)
  );

  assign en_pull   = pull;
  assign bridge_en = en_req & ~pull & ~hot & ~uv;

endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk #(
  parameter int TEMP_W = 8,
  parameter int VS_W   = 8,
  parameter int T_TRIP = 165,
  parameter int V_OFF  = 55
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_req,
  input logic              oc_flag,
  input logic [TEMP_W-1:0] temp_code,
  input logic [VS_W-1:0]   vsup_code,
  input logic              bridge_en,
  input logic              en_pull
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!bridge_en && !en_pull);
    end
  end

  // R2
  req_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |-> !bridge_en);

  // R8
  pull_gates_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_pull |-> !bridge_en);

  // R6
  hot_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= TEMP_W'(T_TRIP)) |=> !bridge_en);

  // R7
  uv_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vsup_code < VS_W'(V_OFF)) |=> !bridge_en);

  // R5
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_pull) |-> !$past(oc_flag));

endmodule

bind bridge_guard bridge_guard_chk #(
  .TEMP_W (TEMP_W),
  .VS_W   (VS_W),
  .T_TRIP (T_TRIP),
  .V_OFF  (V_OFF)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_req    (en_req),
  .oc_flag   (oc_flag),
  .temp_code (temp_code),
  .vsup_code (vsup_code),
  .bridge_en (bridge_en),
  .en_pull   (en_pull)
);

// File: tb/test_bridge_guard.sv
module test_bridge_guard;

  localparam int TW     = 8;
  localparam int VW     = 8;
  localparam int DW     = 3;
  localparam int MW     = 4;
  localparam int T_TRIP = 165;
  localparam int T_HYS  = 15;
  localparam int V_ON   = 63;
  localparam int V_OFF  = 55;

  logic          clk;
  logic          rst_n;
  logic          en_req;
  logic          oc_flag;
  logic [TW-1:0] temp_code;
  logic [VW-1:0] vsup_code;
  logic [DW-1:0] trip_delay;
  logic [MW-1:0] dis_time;
  logic          bridge_en;
  logic          en_pull;

  int checks;
  int errors;
  bit done;

  bridge_guard #(
    .TEMP_W (TW), .VS_W (VW), .DLY_W (DW), .TIME_W (MW),
    .T_TRIP (T_TRIP), .T_HYS (T_HYS), .V_ON (V_ON), .V_OFF (V_OFF)
  ) i_bridge_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_req     (en_req),
    .oc_flag    (oc_flag),
    .temp_code  (temp_code),
    .vsup_code  (vsup_code),
    .trip_delay (trip_delay),
    .dis_time   (dis_time),
    .bridge_en  (bridge_en),
    .en_pull    (en_pull)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives an overcurrent flag high for hi_len sampled edges, then measures
  // the cycles without pull-down before it rises and the pull-down width.
  task automatic oc_run(input int d, input int t, input int hi_len,
                        output int lead, output int width, output int en_bad);
    int seen;
    lead = 0; width = 0; en_bad = 0; seen = 0;
    trip_delay = DW'(d);
    dis_time   = MW'(t);
    oc_flag    = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      seen++;
      if (en_pull && bridge_en) en_bad++;
      if (en_pull) width++;
      else if (width == 0) lead++;
      if (seen >= hi_len) oc_flag = 1'b0;
      if (!en_pull && width > 0) break;
    end
    oc_flag = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lead, width, en_bad, bad_total;
    bit hot_m, uv_m;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; en_req = 1'b0; oc_flag = 1'b0;
    temp_code = TW'(25); vsup_code = '0;
    trip_delay = '0; dis_time = MW'(1);
    repeat (3) @(negedge clk);
    check("R1 reset bridge_en", int'(bridge_en), 0);
    check("R1 reset en_pull", int'(en_pull), 0);

    rst_n = 1'b1; en_req = 1'b1; vsup_code = VW'(60);
    repeat (5) @(negedge clk);
    check("R1 locked between levels", int'(bridge_en), 0);
    vsup_code = VW'(64);
    @(negedge clk);
    check("R1 release above V_ON", int'(bridge_en), 1);

    // R2 combinational request gating
    en_req = 1'b0; #1;
    check("R2 request low", int'(bridge_en), 0);
    en_req = 1'b1; #1;
    check("R2 request high", int'(bridge_en), 1);
    @(negedge clk);

    // R3 R4 exhaustive sweep of delay and hold settings
    bad_total = 0;
    for (int d = 0; d < (1 << DW); d++) begin
      for (int t = 0; t < (1 << MW); t++) begin
        oc_run(d, t, 1, lead, width, en_bad);
        check($sformatf("R3 delay d=%0d t=%0d", d, t), lead, d);
        check($sformatf("R4 hold d=%0d t=%0d", d, t), width, (t == 0) ? 1 : t);
        bad_total += en_bad;
        repeat (2) @(negedge clk);
      end
    end
    check("R8 enable low while pulled", bad_total, 0);
    check("R4 released enable", int'(bridge_en), 1);

    // R5 flag high through delay and hold, dropped before expiry: ignored
    oc_run(2, 4, 6, lead, width, en_bad);
    check("R5 ignored lead", lead, 2);
    check("R5 ignored width", width, 4);
    repeat (2) @(negedge clk);
    // R5 flag still high at expiry: hold restarts
    oc_run(2, 4, 8, lead, width, en_bad);
    check("R5 retrigger width", width, 8);
    repeat (3) @(negedge clk);

    // R8 sequence runs with request low
    en_req = 1'b0;
    oc_run(1, 2, 1, lead, width, en_bad);
    check("R8 width with request low", width, 2);
    check("R8 enable with request low", int'(bridge_en), 0);
    en_req = 1'b1;
    repeat (2) @(negedge clk);

    // R6 temperature ramp up and down
    hot_m = 1'b0;
    for (int v = 150; v <= 180; v++) begin
      temp_code = TW'(v);
      @(negedge clk);
      if (v >= T_TRIP) hot_m = 1'b1;
      else if (v < T_TRIP - T_HYS) hot_m = 1'b0;
      check($sformatf("R6 up temp=%0d", v), int'(bridge_en), int'(!hot_m));
    end
    for (int v = 180; v >= 140; v--) begin
      temp_code = TW'(v);
      @(negedge clk);
      if (v >= T_TRIP) hot_m = 1'b1;
      else if (v < T_TRIP - T_HYS) hot_m = 1'b0;
      check($sformatf("R6 down temp=%0d", v), int'(bridge_en), int'(!hot_m));
    end
    temp_code = TW'(25);
    @(negedge clk);

    // R7 supply ramp down and up
    uv_m = 1'b0;
    for (int v = 70; v >= 40; v--) begin
      vsup_code = VW'(v);
      @(negedge clk);
      if (v < V_OFF) uv_m = 1'b1;
      else if (v > V_ON) uv_m = 1'b0;
      check($sformatf("R7 down vs=%0d", v), int'(bridge_en), int'(!uv_m));
    end
    for (int v = 40; v <= 75; v++) begin
      vsup_code = VW'(v);
      @(negedge clk);
      if (v < V_OFF) uv_m = 1'b1;
      else if (v > V_ON) uv_m = 1'b0;
      check($sformatf("R7 up vs=%0d", v), int'(bridge_en), int'(!uv_m));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule